// File: doc/BRIEF.md
# Windowed Address Widener

This block turns a 32-bit address from an initiator into a 36-bit address for a wider memory system. Four programmable windows are held in the block. Each window has an input base, a size that is a power of two, a 36-bit output base and an enable. An address that falls inside an enabled window is moved into that window's output space. An address that falls in no window goes through unchanged, with four zero bits added at the top. The result is registered, so it appears one clock after the input address.

Windows are set up through a small register port. The port writes in one cycle and reads back at once, with no wait. Each window exposes four words: the input base, the low word of the output base, a control word, and a shared status word. The status word carries a sticky error flag. The flag records that an enabled window had an input base that was not aligned to its size. Such a window is never used for translation.

Top module: `win_remap`

## Requirements
- R1: After a synchronous reset every window is disabled and its size reads as 12. The error flag reads 0. Any input address gives `out_hit`=0 and `out_addr` equal to the zero-extended input.
- R2: The register address is {window[1:0], field[1:0]}. Field 0 is the input base. Field 1 is output base bits 31:0. Field 2 holds enable in bit 0, log2 of the size in bits 13:8, and output base bits 35:32 in bits 19:16. Field 3 holds the error flag in bit 0. A write lands at the clock edge, and reads are combinational.
- R3: A size value written below 12 is stored as 12. A value written above 32 is stored as 32.
- R4: An enabled, aligned window matches an address when the address bits at and above the log2 size equal those of the input base. The lower bits play no part in the match, and a size of 32 matches every address.
- R5: On a match, `out_addr` is the output base OR'd with the input address bits below the log2 size. `out_hit` is 1, and `out_idx` gives the window.
- R6: When several windows match, the lowest-numbered one is used.
- R7: When no window matches, `out_addr` is the input zero-extended to 36 bits and `out_hit` is 0.
- R8: A disabled window never matches.
- R9: An enabled window whose input base has a set bit below its log2 size never matches. It sets the error flag, which then stays set until reset, even after the window is corrected.
- R10: The outputs reflect the input address presented in the cycle before the clock edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Window index and field select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| cfg_err | output | 1 | Sticky misaligned-window flag |
| in_addr | input | 32 | Address to translate |
| out_addr | output | 36 | Translated address, registered |
| out_hit | output | 1 | A window matched the previous address |
| out_idx | output | 2 | Index of the matching window |

## Verification
Several rules are checked on every cycle. An unmatched result is always the zero-extended earlier input. The reported window is never preceded by a lower window that also matched. A misaligned window never raises a match. The error flag never falls outside reset, and stored sizes stay between 12 and 32. Other behaviour needs the bench's scenarios to show it. This includes the exact offset merge at each size, the boundary addresses just inside and just outside a window, the size clamping, the register layout and the whole-space window. The bench sweeps these against an arithmetic model of the requirements.

// File: rtl/win_remap_pkg.sv
// Shared widths, the window record type and the offset-mask helper.
// Assumes the input width is at most the output width and that the
// high output-base bits fit into the 12 spare bits of the control word.
package win_remap_pkg;
    localparam int unsigned IN_W   = 32;
    localparam int unsigned OUT_W  = 36;
    localparam int unsigned NREG   = 4;
    localparam int unsigned LG_W   = 6;
    localparam int unsigned LG_MIN = 12;
    localparam int unsigned LG_MAX = IN_W;
    localparam int unsigned IDX_W  = $clog2(NREG);
    localparam int unsigned HI_W   = OUT_W - IN_W;

    typedef struct packed {
        logic              en;
        logic [LG_W-1:0]   lg;
        logic [IN_W-1:0]   ib;
        logic [OUT_W-1:0]  ob;
    } region_t;

    // Ones in the offset bits below the window size.
    function automatic logic [IN_W-1:0] low_mask(input logic [LG_W-1:0] lg);
        if (lg >= LG_W'(IN_W)) return '1;
        return ~({IN_W{1'b1}} << lg);
    endfunction
endpackage

// File: rtl/win_remap_cfg.sv
// Window register file: stores four windows, clamps sizes, serves
// combinational readback and keeps the sticky misalignment flag.
// Assumes cfg_addr = {window, field}, one write per cycle.
module win_remap_cfg
    import win_remap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [IDX_W+1:0]   addr,
    input  logic [IN_W-1:0]    wdata,
    output logic [IN_W-1:0]    rdata,
    output logic               err,
    output logic [NREG-1:0]    bad,
    output region_t            regs [NREG]
);
    logic [IDX_W-1:0] sel;
    logic [1:0]       fld;
    assign sel = addr[IDX_W+1:2];
    assign fld = addr[1:0];

    // Bound a requested size to the legal range.
    function automatic logic [LG_W-1:0] clamp(input logic [LG_W-1:0] v);
        if (v < LG_W'(LG_MIN)) return LG_W'(LG_MIN);
        if (v > LG_W'(LG_MAX)) return LG_W'(LG_MAX);
        return v;
    endfunction

    // Flag enabled windows whose input base is not size aligned.
    always_comb begin
        for (int r = 0; r < NREG; r++)
            bad[r] = regs[r].en && |(regs[r].ib & low_mask(regs[r].lg));
    end

    // Register writes and sticky error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                regs[r].en <= 1'b0;
                regs[r].lg <= LG_W'(LG_MIN);
                regs[r].ib <= '0;
                regs[r].ob <= '0;
            end
            err <= 1'b0;
        end else begin
            if (wr) begin
                case (fld)
                    2'd0: regs[sel].ib <= wdata;
                    2'd1: regs[sel].ob[IN_W-1:0] <= wdata;
                    2'd2: begin
                        regs[sel].en <= wdata[0];
                        regs[sel].lg <= clamp(wdata[8 +: LG_W]);
                        regs[sel].ob[OUT_W-1 -: HI_W] <= wdata[16 +: HI_W];
                    end
                    default: ;
                endcase
            end
            if (|bad) err <= 1'b1;
        end
    end

    // Combinational readback of the selected field.
    always_comb begin
        rdata = '0;
        case (fld)
            2'd0: rdata = regs[sel].ib;
            2'd1: rdata = regs[sel].ob[IN_W-1:0];
            2'd2: begin
                rdata[0]           = regs[sel].en;
                rdata[8 +: LG_W]   = regs[sel].lg;
                rdata[16 +: HI_W]  = regs[sel].ob[OUT_W-1 -: HI_W];
            end
            default: rdata[0] = err;
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[g].lg >= LG_W'(LG_MIN)) && (regs[g].lg <= LG_W'(LG_MAX)));
    end
endmodule

// File: rtl/win_remap_match.sv
// One window comparator: decides a hit and forms the widened address.
// Assumes the window's size field is already within the legal range.
module win_remap_match
    import win_remap_pkg::*;
(
    input  region_t            rg,
    input  logic [IN_W-1:0]    a,
    output logic               hit,
    output logic [OUT_W-1:0]   xa
);
    logic [IN_W-1:0] m;
    logic            aligned;

    // Compare the high bits and merge the offset into the output base.
    always_comb begin
        m       = low_mask(rg.lg);
        aligned = ((rg.ib & m) == '0);
        hit     = rg.en && aligned && ((a & ~m) == (rg.ib & ~m));
        xa      = rg.ob | OUT_W'(a & m);
    end
endmodule

// File: rtl/win_remap_pick.sv
// Fixed-priority selector: the lowest-numbered hitting window wins,
// otherwise the input passes through zero-extended.
module win_remap_pick
    import win_remap_pkg::*;
(
    input  logic [NREG-1:0]    hit,
    input  logic [OUT_W-1:0]   xa [NREG],
    input  logic [IN_W-1:0]    a,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [OUT_W-1:0]   addr
);
    // Scan from the top so the lowest hit is written last.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        addr = OUT_W'(a);
        for (int r = NREG - 1; r >= 0; r--) begin
            if (hit[r]) begin
                any  = 1'b1;
                idx  = IDX_W'(r);
                addr = xa[r];
            end
        end
    end
endmodule

// File: rtl/win_remap.sv
// Top: four-window 32-to-36-bit address widener with a register port
// and a registered result (one cycle latency).
// Assumes windows are reprogrammed while results may be ignored.
module win_remap
    import win_remap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [3:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic               cfg_err,
    input  logic [31:0]        in_addr,
    output logic [35:0]        out_addr,
    output logic               out_hit,
    output logic [1:0]         out_idx
);
    region_t           regs [NREG];
    logic [NREG-1:0]   bad_v;
    logic [NREG-1:0]   hit_v;
    logic [OUT_W-1:0]  xa_v [NREG];
    logic              any;
    logic [IDX_W-1:0]  idx;
    logic [OUT_W-1:0]  addr_n;
    logic              past_ok;

    win_remap_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .err(cfg_err),
        .bad(bad_v), .regs(regs)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_win
        win_remap_match u_m (.rg(regs[g]), .a(in_addr), .hit(hit_v[g]), .xa(xa_v[g]));

        assert_misaligned_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            bad_v[g] |-> !hit_v[g]);
    end

    win_remap_pick u_pick (
        .hit(hit_v), .xa(xa_v), .a(in_addr),
        .any(any), .idx(idx), .addr(addr_n)
    );

    // Register the translation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_hit  <= 1'b0;
            out_idx  <= '0;
        end else begin
            out_addr <= addr_n;
            out_hit  <= any;
            out_idx  <= idx;
        end
    end

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !out_hit) |-> (out_addr == OUT_W'($past(in_addr))));

    assert_hit_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_hit == $past(|hit_v)));

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_hit) |->
        (($past(hit_v) & ((NREG'(1) << out_idx) - NREG'(1))) == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_err)) |-> cfg_err);
endmodule

// File: tb/sim_win_remap.sv
// Self-checking bench: programs windows and sweeps addresses against
// an arithmetic model of the requirements.
module sim_win_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic [31:0] in_addr = '0;
    logic [35:0] out_addr;
    logic        out_hit;
    logic [1:0]  out_idx;

    int tests = 0;
    int fails = 0;

    bit          sh_en [4];
    int          sh_lg [4];
    logic [31:0] sh_ib [4];
    logic [35:0] sh_ob [4];

    always #10 clk = ~clk;

    win_remap u0 (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int r, input int f, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'((r << 2) | f); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_win(input int r, input logic [31:0] ib, input int lg,
                           input logic [35:0] ob, input bit en);
        wr_reg(r, 0, ib);
        wr_reg(r, 1, ob[31:0]);
        wr_reg(r, 2, {12'd0, ob[35:32], 2'd0, 6'(lg), 7'd0, en});
        sh_en[r] = en; sh_ib[r] = ib; sh_ob[r] = ob;
        sh_lg[r] = (lg < 12) ? 12 : (lg > 32) ? 32 : lg;
    endtask

    // Expected result computed from R4..R9.
    task automatic model(input logic [31:0] a, output bit h, output int idx, output logic [35:0] o);
        h = 0; idx = 0; o = {4'd0, a};
        for (int r = 3; r >= 0; r--) begin
            logic [63:0] m;
            m = (64'd1 << sh_lg[r]) - 64'd1;
            if (sh_en[r] && (({32'd0, sh_ib[r]} & m) == 0) &&
                (({32'd0, a} & ~m) == ({32'd0, sh_ib[r]} & ~m))) begin
                h = 1; idx = r; o = sh_ob[r] | 36'({32'd0, a} & m);
            end
        end
    endtask

    task automatic probe(input logic [31:0] a, input string req);
        bit h; int idx; logic [35:0] o;
        @(negedge clk);
        in_addr = a;
        @(negedge clk);              // one edge later: R10 latency
        model(a, h, idx, o);
        check(out_hit == h, {req, " hit"}, 64'(out_hit), 64'(h));
        check(out_addr == o, {req, " addr"}, 64'(out_addr), 64'(o));
        if (h) check(out_idx == 2'(idx), {req, " idx"}, 64'(out_idx), 64'(idx));
    endtask

    task automatic rd(input int r, input int f, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = 4'((r << 2) | f);
        #1;
        check(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            sh_en[r] = 0; sh_lg[r] = 12; sh_ib[r] = 0; sh_ob[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, 2, 32'h0000_0C00, "R1 ctrl reset");
        rd(3, 3, 32'h0, "R1 err reset");
        probe(32'hFFFF_FFFF, "R1 passthru");
        probe(32'h1234_5678, "R1 passthru");

        // R2 R5: a 64KB window
        set_win(0, 32'h1000_0000, 16, 36'hA_2000_0000, 1);
        rd(0, 0, 32'h1000_0000, "R2 ibase readback");
        rd(0, 1, 32'h2000_0000, "R2 obase readback");
        rd(0, 2, 32'h000A_1001, "R2 ctrl readback");
        probe(32'h1000_0000, "R5 base");
        probe(32'h1000_FFFF, "R4 top of window");
        probe(32'h0FFF_FFFF, "R4 below window");
        probe(32'h1001_0000, "R4 above window");
        probe(32'h1000_1234, "R5 offset");

        // R6: overlapping 1MB window at index 1
        set_win(1, 32'h1000_0000, 20, 36'h5_0000_0000, 1);
        probe(32'h1000_0010, "R6 lower index wins");
        probe(32'h1008_0000, "R6 only upper");
        // R8: disabling window 0
        set_win(0, 32'h1000_0000, 16, 36'hA_2000_0000, 0);
        probe(32'h1000_0010, "R8 disabled skipped");

        // R4 R3: whole-space window at index 2, size written too large
        set_win(2, 32'h0, 40, 36'hF_0000_0000, 1);
        rd(2, 2, 32'h000F_2001, "R3 clamp high");
        probe(32'h8765_4321, "R4 whole space");
        probe(32'h1000_0004, "R6 window1 over window2");
        set_win(2, 32'h0, 32, 36'hF_0000_0000, 0);

        // R3: size written too small
        set_win(3, 32'h3000_0000, 3, 36'h1_0000_0000, 1);
        rd(3, 2, 32'h0001_0C01, "R3 clamp low");
        probe(32'h3000_0FFF, "R3 4KB window");
        probe(32'h3000_1000, "R3 past 4KB");

        // R9: misaligned window, sticky error
        set_win(3, 32'h2000_0800, 12, 36'h1_0000_0000, 1);
        probe(32'h2000_0800, "R9 misaligned no hit");
        rd(0, 3, 32'h1, "R9 err set");
        set_win(3, 32'h2000_0000, 12, 36'h1_0000_0000, 1);
        probe(32'h2000_0800, "R9 fixed window hits");
        rd(1, 3, 32'h1, "R9 err sticky");

        // R4 R5 R7: sweep sizes and addresses around window 0
        set_win(1, 32'h0, 12, 36'h0, 0);
        set_win(3, 32'h0, 12, 36'h0, 0);
        for (int lg = 12; lg <= 20; lg += 2) begin
            set_win(0, 32'h4010_0000, lg, 36'h7_0000_0000 | 36'(lg), 1);
            for (int k = -2; k <= 5; k++) begin
                logic [31:0] a;
                a = 32'h4010_0000 + 32'(k * (1 << (lg - 1))) + 32'd3;
                probe(a, "R4 R5 R7 sweep");
            end
        end

        // R1: reset clears windows and error
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < 4; r++) begin sh_en[r] = 0; sh_lg[r] = 12; end
        rd(0, 3, 32'h0, "R1 err cleared");
        probe(32'h4010_0003, "R1 no window after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule